// File: doc/BRIEF.md
# Mode-Selectable 16-bit Timer Counter

This block is a 16-bit up-counter with a 3-bit operating mode. The counter advances only on cycles where a count-enable tick is high. Depending on the mode it is held at zero, runs freely and wraps, restarts from zero on each strobe from an external input that has already been edge-detected, or restarts from zero when it matches the first compare register. Two compare registers raise a one-cycle interrupt pulse on a match. The same matches toggle a timer output. When the low mode bit is set, the external strobe toggles that output too.

A sticky overflow flag records every roll of the counter from its all-ones value to zero. This includes the roll caused by a compare-0 clear when compare 0 holds all ones. Software reaches the mode, the overflow flag and both compare values through a simple register write port. The current mode is visible on an output, so software can see whether a write was accepted.

Top module: `mode_timer16`

## Requirements
- R1: After reset, the mode reads 000 and count, interrupt, timer output and overflow flag all read 0.
- R2: In modes 000 and 001 (stopped), from the cycle after the mode register holds such a value, count reads 0 and no interrupt is raised. The timer output does not change, whatever the tick, strobe or compare values.
- R3: In a running mode (upper two mode bits not 00), count increments by one at each clock edge where the tick is high and no clear applies. It holds when the tick is low.
- R4: In modes 010 and 011, the count wraps from FFFFh to 0000h, and the external strobe never clears it.
- R5: In modes 100 and 101, a cycle with the external strobe high loads 0 into the count. This clear takes priority over a tick in the same cycle.
- R6: In modes 110 and 111, a tick cycle in which the count equals compare 0 loads 0 in place of the increment.
- R7: A match event is a tick cycle in a running mode where the count equals compare 0 or compare 1. The interrupt output is high for exactly the cycle after each match event.
- R8: In a running mode, the timer output toggles once at the end of a cycle that holds a match event, or, when mode bit 0 is 1, a strobe. A match and a strobe in the same cycle give a single toggle.
- R9: In a running mode, a tick cycle with count FFFFh sets the overflow flag. This also holds in modes 110/111 with compare 0 at FFFFh.
- R10: The overflow flag is sticky. A control write loads it from data bit 0 at any time. A hardware set in the same cycle wins over a written 0.
- R11: A control write loads data bits [3:1] into the mode if the new value is 000/001, or if the current mode is 000/001. Otherwise the mode stays unchanged.
- R12: Write address 0 is control (bits [3:1] mode, bit 0 overflow). Address 1 loads compare 0 and address 2 loads compare 1, each from all 16 data bits, at any time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cnt_tick | input | 1 | Count enable for this cycle |
| ext_strobe | input | 1 | Edge-detected external input event |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Register select: 0 control, 1 compare 0, 2 compare 1 |
| wr_data | input | 16 | Write data |
| count_o | output | 16 | Current counter value |
| mode_o | output | 3 | Current mode field |
| irq_o | output | 1 | One-cycle interrupt request pulse |
| tout_o | output | 1 | Toggling timer output |
| ovf_o | output | 1 | Sticky overflow flag |

## Verification
The bench runs the counter in compare-0 clear mode with compare 0 at FFFFh. It then writes 0 to the overflow flag in the exact cycle of the roll. A design that misses the wrap-by-clear case, or that lets the software write win, leaves the flag at 0. A strobe and a tick in the same cycle in an edge-clear mode catch a design that gives the increment priority. A strobe that coincides with a compare match in a mode with bit 0 set catches a design that toggles twice and so leaves the output unchanged. The bench also writes a new running mode while the timer runs and issues compare matches while the timer is stopped. A design that accepts the write, or that counts or pulses while stopped, differs on the mode, count or interrupt outputs.

// File: rtl/mtc_pkg.sv
package mtc_pkg;
   typedef enum logic [1:0] {
      OPC_STOP  = 2'b00,
      OPC_FREE  = 2'b01,
      OPC_EDGE  = 2'b10,
      OPC_MATCH = 2'b11
   } op_class_e;

   localparam int MODE_W    = 3;
   localparam int MODE_LSB  = 1;
   localparam int OVF_BIT   = 0;
   localparam int ADDR_CTRL = 0;
   localparam int ADDR_CMP0 = 1;

   function automatic op_class_e op_class(input logic [MODE_W-1:0] m);
      return op_class_e'(m[MODE_W-1:1]);
   endfunction
endpackage

// File: rtl/mtc_regs.sv
module mtc_regs
   import mtc_pkg::*;
#(
   parameter int CNT_W   = 16,
   parameter int ADDR_W  = 2,
   parameter int NUM_CMP = 2
) (
   input  logic                            clk,
   input  logic                            rst_n,
   input  logic                            wr_en,
   input  logic [ADDR_W-1:0]               wr_addr,
   input  logic [CNT_W-1:0]                wr_data,
   output logic [MODE_W-1:0]               mode_q,
   output logic [NUM_CMP-1:0][CNT_W-1:0]   cmp_q,
   output logic                            ovf_wr,
   output logic                            ovf_wdata
);
   localparam int MODE_MSB = MODE_LSB + MODE_W - 1;

   logic                ctrl_sel;
   logic [MODE_W-1:0]   mode_new;
   logic                mode_accept;

   assign ctrl_sel  = wr_en && (wr_addr == ADDR_W'(ADDR_CTRL));
   assign mode_new  = wr_data[MODE_MSB:MODE_LSB];
   assign ovf_wr    = ctrl_sel;
   assign ovf_wdata = wr_data[OVF_BIT];

   always_comb begin
      mode_accept = 1'b0;
      if (ctrl_sel) begin
         if (op_class(mode_new) == OPC_STOP || op_class(mode_q) == OPC_STOP)
            mode_accept = 1'b1;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)           mode_q <= '0;
      else if (mode_accept) mode_q <= mode_new;
   end

   for (genvar gi = 0; gi < NUM_CMP; gi++) begin : g_cmp
      logic hit;
      assign hit = wr_en && (wr_addr == ADDR_W'(ADDR_CMP0 + gi));
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)   cmp_q[gi] <= '0;
         else if (hit) cmp_q[gi] <= wr_data;
      end
   end
endmodule

// File: rtl/mtc_events.sv
module mtc_events
   import mtc_pkg::*;
#(
   parameter int CNT_W   = 16,
   parameter int NUM_CMP = 2
) (
   input  logic [MODE_W-1:0]               mode_q,
   input  logic [CNT_W-1:0]                count_q,
   input  logic [NUM_CMP-1:0][CNT_W-1:0]   cmp_q,
   input  logic                            cnt_tick,
   input  logic                            ext_strobe,
   output logic                            running,
   output logic                            clear_req,
   output logic                            match_any,
   output logic                            toggle_req,
   output logic                            wrap_hit
);
   localparam logic [CNT_W-1:0] ALL_ONES = '1;

   op_class_e          cls;
   logic [NUM_CMP-1:0] match_vec;
   logic               strobe_toggles;

   assign cls     = op_class(mode_q);
   assign running = (cls != OPC_STOP);

   for (genvar gi = 0; gi < NUM_CMP; gi++) begin : g_cmpare
      assign match_vec[gi] = running && cnt_tick && (count_q == cmp_q[gi]);
   end

   assign match_any      = |match_vec;
   assign strobe_toggles = mode_q[0] && ext_strobe;

   always_comb begin
      clear_req = 1'b0;
      unique case (cls)
         OPC_EDGE:  clear_req = ext_strobe;
         OPC_MATCH: clear_req = match_vec[0];
         default:   clear_req = 1'b0;
      endcase
   end

   assign toggle_req = running && (match_any || strobe_toggles);
   assign wrap_hit   = running && cnt_tick && (count_q == ALL_ONES);
endmodule

// File: rtl/mtc_counter.sv
module mtc_counter #(
   parameter int CNT_W = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              running,
   input  logic              clear_req,
   input  logic              cnt_tick,
   output logic [CNT_W-1:0]  count_q
);
   logic [CNT_W-1:0] count_d;

   always_comb begin
      if (!running || clear_req) count_d = '0;
      else if (cnt_tick)         count_d = count_q + CNT_W'(1);
      else                       count_d = count_q;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) count_q <= '0;
      else        count_q <= count_d;
   end
endmodule

// File: rtl/mtc_flags.sv
module mtc_flags (
   input  logic clk,
   input  logic rst_n,
   input  logic match_any,
   input  logic toggle_req,
   input  logic wrap_hit,
   input  logic ovf_wr,
   input  logic ovf_wdata,
   output logic irq_q,
   output logic tout_q,
   output logic ovf_q
);
   logic ovf_d;

   always_comb begin
      if (wrap_hit)    ovf_d = 1'b1;
      else if (ovf_wr) ovf_d = ovf_wdata;
      else             ovf_d = ovf_q;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         irq_q  <= 1'b0;
         tout_q <= 1'b0;
         ovf_q  <= 1'b0;
      end else begin
         irq_q  <= match_any;
         tout_q <= tout_q ^ toggle_req;
         ovf_q  <= ovf_d;
      end
   end
endmodule

// File: rtl/mode_timer16.sv
module mode_timer16
   import mtc_pkg::*;
#(
   parameter int CNT_W   = 16,
   parameter int ADDR_W  = 2,
   parameter int NUM_CMP = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cnt_tick,
   input  logic              ext_strobe,
   input  logic              wr_en,
   input  logic [ADDR_W-1:0] wr_addr,
   input  logic [CNT_W-1:0]  wr_data,
   output logic [CNT_W-1:0]  count_o,
   output logic [MODE_W-1:0] mode_o,
   output logic              irq_o,
   output logic              tout_o,
   output logic              ovf_o
);
   localparam int NUM_REGS = NUM_CMP + 1;

   if (CNT_W < MODE_W + 1) begin : g_bad_width
      $error("CNT_W too narrow for the control field");
   end
   if (NUM_CMP < 1) begin : g_bad_cmp
      $error("NUM_CMP must be at least 1");
   end
   if (NUM_REGS > (1 << ADDR_W)) begin : g_bad_addr
      $error("ADDR_W cannot reach every register");
   end

   logic [MODE_W-1:0]             mode_q;
   logic [NUM_CMP-1:0][CNT_W-1:0] cmp_q;
   logic [CNT_W-1:0]              count_q;
   logic ovf_wr, ovf_wdata;
   logic running, clear_req, match_any, toggle_req, wrap_hit;

   mtc_regs #(.CNT_W(CNT_W), .ADDR_W(ADDR_W), .NUM_CMP(NUM_CMP)) regs_i (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
      .wr_data(wr_data), .mode_q(mode_q), .cmp_q(cmp_q),
      .ovf_wr(ovf_wr), .ovf_wdata(ovf_wdata)
   );

   mtc_events #(.CNT_W(CNT_W), .NUM_CMP(NUM_CMP)) events_i (
      .mode_q(mode_q), .count_q(count_q), .cmp_q(cmp_q),
      .cnt_tick(cnt_tick), .ext_strobe(ext_strobe),
      .running(running), .clear_req(clear_req), .match_any(match_any),
      .toggle_req(toggle_req), .wrap_hit(wrap_hit)
   );

   mtc_counter #(.CNT_W(CNT_W)) counter_i (
      .clk(clk), .rst_n(rst_n), .running(running), .clear_req(clear_req),
      .cnt_tick(cnt_tick), .count_q(count_q)
   );

   mtc_flags flags_i (
      .clk(clk), .rst_n(rst_n), .match_any(match_any),
      .toggle_req(toggle_req), .wrap_hit(wrap_hit), .ovf_wr(ovf_wr),
      .ovf_wdata(ovf_wdata), .irq_q(irq_o), .tout_q(tout_o), .ovf_q(ovf_o)
   );

   assign count_o = count_q;
   assign mode_o  = mode_q;
endmodule

// File: rtl/mtc_checker.sv
module mtc_checker #(
   parameter int CNT_W  = 16,
   parameter int ADDR_W = 2
) (
   input logic              clk,
   input logic              rst_n,
   input logic              cnt_tick,
   input logic              ext_strobe,
   input logic              wr_en,
   input logic [ADDR_W-1:0] wr_addr,
   input logic [CNT_W-1:0]  wr_data,
   input logic [CNT_W-1:0]  count_o,
   input logic [2:0]        mode_o,
   input logic              irq_o,
   input logic              tout_o,
   input logic              ovf_o
);
   logic ctrl_wr, stopped;
   assign ctrl_wr = wr_en && (wr_addr == '0);
   assign stopped = (mode_o[2:1] == 2'b00);

   // R2
   stopped_count_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      stopped |=> (count_o == '0));

   // R2
   stopped_tout_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      stopped |=> $stable(tout_o));

   // R3
   hold_without_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!stopped && !cnt_tick && !ext_strobe) |=> $stable(count_o));

   // R7
   irq_source_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!stopped && !cnt_tick) |=> !irq_o);

   // R10
   ovf_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (ovf_o && !ctrl_wr) |=> ovf_o);

   // R11
   mode_locked_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!stopped && !(ctrl_wr && wr_data[3:2] == 2'b00)) |=> $stable(mode_o));
endmodule

bind mode_timer16 mtc_checker #(.CNT_W(CNT_W), .ADDR_W(ADDR_W)) chk_i (
   .clk(clk), .rst_n(rst_n), .cnt_tick(cnt_tick), .ext_strobe(ext_strobe),
   .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data), .count_o(count_o),
   .mode_o(mode_o), .irq_o(irq_o), .tout_o(tout_o), .ovf_o(ovf_o)
);

// File: tb/mode_timer16_tb.sv
module mode_timer16_tb_top;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        cnt_tick = 1'b0;
   logic        ext_strobe = 1'b0;
   logic        wr_en = 1'b0;
   logic [1:0]  wr_addr = '0;
   logic [15:0] wr_data = '0;
   logic [15:0] count_o;
   logic [2:0]  mode_o;
   logic        irq_o, tout_o, ovf_o;

   always #4 clk = ~clk;

   mode_timer16 dut_i (
      .clk(clk), .rst_n(rst_n), .cnt_tick(cnt_tick), .ext_strobe(ext_strobe),
      .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data), .count_o(count_o),
      .mode_o(mode_o), .irq_o(irq_o), .tout_o(tout_o), .ovf_o(ovf_o)
   );

   typedef struct {
      logic [15:0] cnt;
      logic [2:0]  mode;
      logic        irq, tout, ovf;
      string       tag;
   } exp_t;

   exp_t q[$];
   int   n_vec = 0;
   int   n_bad = 0;
   bit   done = 0;

   logic [2:0]  m_mode = '0;
   logic [15:0] m_cnt = '0, m_c0 = '0, m_c1 = '0;
   logic        m_tout = 0, m_ovf = 0;

   task automatic step(input bit tk, input bit ev, input bit we,
                       input logic [1:0] ad, input logic [15:0] dt, input string tag);
      exp_t e;
      bit run, m0, m1, clr;
      @(negedge clk);
      cnt_tick = tk; ext_strobe = ev; wr_en = we; wr_addr = ad; wr_data = dt;
      run = (m_mode[2:1] != 2'b00);
      m0  = run && tk && (m_cnt == m_c0);
      m1  = run && tk && (m_cnt == m_c1);
      clr = run && ((m_mode[2:1] == 2'b10 && ev) || (m_mode[2:1] == 2'b11 && m0));
      e.irq  = m0 | m1;
      e.tout = m_tout ^ (run && (m0 || m1 || (m_mode[0] && ev)));
      if (run && tk && m_cnt == 16'hFFFF) e.ovf = 1'b1;
      else if (we && ad == 2'd0)          e.ovf = dt[0];
      else                                e.ovf = m_ovf;
      if (!run || clr) e.cnt = '0;
      else if (tk)     e.cnt = m_cnt + 16'd1;
      else             e.cnt = m_cnt;
      e.mode = m_mode;
      if (we && ad == 2'd0 && (dt[3:2] == 2'b00 || !run)) e.mode = dt[3:1];
      if (we && ad == 2'd1) m_c0 = dt;
      if (we && ad == 2'd2) m_c1 = dt;
      e.tag = tag;
      q.push_back(e);
      m_cnt = e.cnt; m_mode = e.mode; m_tout = e.tout; m_ovf = e.ovf;
   endtask

   task automatic idle(input bit tk, input bit ev, input string tag);
      step(tk, ev, 1'b0, 2'd0, 16'h0000, tag);
   endtask

   task automatic wr(input logic [1:0] ad, input logic [15:0] dt, input string tag);
      step(1'b0, 1'b0, 1'b1, ad, dt, tag);
   endtask

   // Control word: mode in bits [3:1], overflow in bit 0
   function automatic logic [15:0] ctl(input logic [2:0] m, input bit o);
      return {12'h000, m, o};
   endfunction

   // monitor / scoreboard
   initial begin
      forever begin
         @(posedge clk);
         #2;
         if (q.size() > 0) begin
            exp_t e;
            e = q.pop_front();
            n_vec++;
            if (count_o !== e.cnt || mode_o !== e.mode || irq_o !== e.irq ||
                tout_o !== e.tout || ovf_o !== e.ovf) begin
               n_bad++;
               $display("FAIL %s: cnt=%h mode=%b irq=%b tout=%b ovf=%b, expected cnt=%h mode=%b irq=%b tout=%b ovf=%b",
                        e.tag, count_o, mode_o, irq_o, tout_o, ovf_o,
                        e.cnt, e.mode, e.irq, e.tout, e.ovf);
            end
         end
      end
   end

   // watchdog
   initial begin
      repeat (195000) @(posedge clk);
      if (!done) begin
         n_bad++;
         $display("FAIL watchdog: run incomplete, expected completion");
         $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      // R1 reset state
      idle(0, 0, "R1");
      // R12 compare writes; R2 stopped with matching compares and strobes
      wr(2'd1, 16'h0000, "R12");
      wr(2'd2, 16'h0001, "R12");
      for (int i = 0; i < 4; i++) idle(1, i[0], "R2");
      wr(2'd0, ctl(3'b001, 0), "R11");
      for (int i = 0; i < 4; i++) idle(1, 1, "R2");
      // free-running, mode 010
      wr(2'd1, 16'd5, "R12");
      wr(2'd2, 16'd9, "R12");
      wr(2'd0, ctl(3'b010, 0), "R11");
      for (int i = 0; i < 24; i++) idle(i % 3 != 0, i[2], "R3 R7 R8");
      // R11 running mode write ignored; R10 overflow write while running
      wr(2'd0, ctl(3'b100, 1), "R11 R10");
      idle(1, 0, "R10");
      wr(2'd0, ctl(3'b010, 0), "R10");
      // stop then mode 011: strobes toggle, no clear
      wr(2'd0, ctl(3'b000, 0), "R11");
      idle(1, 0, "R2");
      wr(2'd0, ctl(3'b011, 0), "R11");
      for (int i = 0; i < 12; i++) idle(1, i % 4 == 1, "R4 R8");
      // mode 101: strobe clears, beats tick
      wr(2'd0, ctl(3'b000, 0), "R11");
      wr(2'd0, ctl(3'b101, 0), "R11");
      for (int i = 0; i < 14; i++) idle(1, i % 5 == 4, "R5 R8");
      idle(0, 1, "R5");
      // mode 100: strobe clears but does not toggle
      wr(2'd0, ctl(3'b000, 0), "R11");
      wr(2'd0, ctl(3'b100, 0), "R11");
      for (int i = 0; i < 10; i++) idle(1, i == 3 || i == 7, "R5 R8");
      // mode 110, compare 0 = 3
      wr(2'd0, ctl(3'b000, 0), "R11");
      wr(2'd1, 16'd3, "R12");
      wr(2'd2, 16'd2, "R12");
      wr(2'd0, ctl(3'b110, 0), "R11");
      for (int i = 0; i < 14; i++) idle(i != 6, 0, "R6 R7");
      // mode 111: strobe coinciding with a compare match toggles once
      wr(2'd0, ctl(3'b000, 0), "R11");
      wr(2'd0, ctl(3'b111, 0), "R11");
      for (int i = 0; i < 12; i++) idle(1, 1, "R8");
      // compare 0 = FFFF in clear mode: roll with coincident overflow write of 0
      wr(2'd0, ctl(3'b000, 0), "R11");
      wr(2'd1, 16'hFFFF, "R12");
      wr(2'd2, 16'h8000, "R12");
      wr(2'd0, ctl(3'b110, 0), "R11");
      for (int i = 0; i < 65535; i++) idle(1, 0, "R6 R7");
      step(1, 0, 1, 2'd0, ctl(3'b110, 0), "R9 R10");
      idle(1, 0, "R9 R10");
      wr(2'd0, ctl(3'b110, 0), "R10");
      // free-running wrap
      wr(2'd0, ctl(3'b000, 0), "R11");
      wr(2'd0, ctl(3'b010, 0), "R11");
      for (int i = 0; i < 65536; i++) idle(1, (i % 4096) == 7, "R4 R9");
      idle(1, 0, "R4 R9");
      idle(0, 0, "R10");
      // stop: count clears, no further pulses
      wr(2'd0, ctl(3'b000, 1), "R2");
      idle(1, 1, "R2");
      idle(1, 1, "R2");
      repeat (3) @(posedge clk);
      done = 1;
      $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
   end
endmodule